// File: doc/BRIEF.md
# PHY Interrupt and Isolate Controller

This block sits behind the management register port of an Ethernet physical layer device. It keeps a set of sticky event flags with a matching enable mask, and drives an active-high interrupt whenever an enabled flag is pending. It holds the control bit that cuts the MII data path off from the MAC, and it keeps the station address register. It also holds a configuration flag that asks the serial management logic to carry the interrupt in-band on the management data line. How that in-band signalling is done is outside this block. The block only presents the flag.

Management logic drives single-cycle read and write strobes together with a 5-bit register number and 16-bit write data. Read data is returned combinationally in the same cycle as the read strobe. Event sources pulse one bit of `evt_pulse` for one cycle. The isolate decision is held in a two-state machine: `ISO_LIVE` means the data path is connected, and `ISO_HELD` means it is isolated. The machine has two transitions. `GO_HELD` is taken when the isolate control bit is 1 or the stored station address is zero. `GO_LIVE` is taken when neither holds. The machine's state drives the output enables for the MII outputs and the acceptance of the transmit inputs.

Top module: `phy_irq_iso_ctrl`

## Requirements
- R1: `irq` is high exactly when some bit of the event flag register (number 1Eh) is 1 and the same bit of the mask register (number 1Dh, bits N_EVT-1:0) is 1. A mask bit of 1 enables its source. The mask resets to all zeros.
- R2: A pulse on `evt_pulse[i]` sets flag bit i of register 1Eh at the next clock edge. The flag stays set until register 1Eh is read.
- R3: A read of register 1Eh returns the flags on `reg_rdata` in the same cycle and clears them at the closing clock edge, so `irq` drops after that edge.
- R4: An event pulse in the same cycle as a clearing read of 1Eh survives. Its flag bit is 1 after the edge.
- R5: A write to register 1Eh changes no flag. The flags read back unchanged afterwards.
- R6: Bit 11 of register 17h is writable and readable, drives `irq_on_mdio`, and resets to 0.
- R7: At reset, bit 10 of register 0h is 1 if `strap_addr` is 0 and 0 otherwise, and register 19h bits 15:11 take the value of `strap_addr`.
- R8: `isolate` is high in the cycle after an edge at which bit 10 of register 0h is 1 or register 19h bits 15:11 are zero, and low otherwise. Writing a zero station address leaves bit 10 of register 0h unchanged on readback.
- R9: While `isolate` is high, `mii_out_en` and `tx_accept` are 0, and register reads and writes still work.
- R10: `reg_rdata` is 0 when `reg_rd` is low or the register number is not 0h, 17h, 19h, 1Dh or 1Eh. All unused bits of the mapped registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Strapped station address, sampled during reset |
| evt_pulse | input | N_EVT | Single-cycle event pulses, one per flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register number |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with `reg_rd` |
| irq | output | 1 | Active-high interrupt |
| irq_on_mdio | output | 1 | Request to carry the interrupt on the management data line |
| isolate | output | 1 | Data path isolated |
| mii_out_en | output | 1 | Output enable for the MII clocks, receive signals, COL and CRS |
| tx_accept | output | 1 | Transmit data, enable and error inputs are honoured |

## Verification
Two functions can act in the same cycle. An event source can set a flag in the very cycle in which a read of 1Eh clears the flag register. The management port can also write a zero station address or a new isolate bit while events keep arriving. The bench provokes both cases on purpose in directed steps. It also produces them by chance, using random event pulses mixed with random reads and writes. A bench model updated from the requirements judges every cycle. After a clearing read, it expects only the bits pulsed in that cycle to remain, and it expects the isolate output one edge after the register values change.

// File: rtl/phy_irq_iso_pkg.sv
package phy_irq_iso_pkg;
    localparam int REG_AW = 5;
    localparam int REG_DW = 16;
    localparam logic [REG_AW-1:0] RA_CTRL   = 5'h00;
    localparam logic [REG_AW-1:0] RA_IRQCFG = 5'h17;
    localparam logic [REG_AW-1:0] RA_STNADR = 5'h19;
    localparam logic [REG_AW-1:0] RA_MASK   = 5'h1D;
    localparam logic [REG_AW-1:0] RA_FLAGS  = 5'h1E;
    localparam int ISO_BIT  = 10;
    localparam int MDIO_BIT = 11;
    localparam int ADR_LSB  = 11;

    typedef enum logic {
        ISO_LIVE = 1'b0,
        ISO_HELD = 1'b1
    } iso_state_t;
endpackage

// File: rtl/pii_irq_bank.sv
module pii_irq_bank #(
    parameter int N_EVT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic             clr,
    input  logic             mask_we,
    input  logic [N_EVT-1:0] mask_wdata,
    output logic [N_EVT-1:0] flags,
    output logic [N_EVT-1:0] mask,
    output logic             irq
);
    logic [N_EVT-1:0] flags_q;
    logic [N_EVT-1:0] mask_q;

    for (genvar i = 0; i < N_EVT; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else begin
                flags_q[i] <= (flags_q[i] & ~clr) | evt[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    assign flags = flags_q;
    assign mask  = mask_q;
    assign irq   = |(flags_q & mask_q);
endmodule

// File: rtl/pii_cfg_regs.sv
module pii_cfg_regs
    import phy_irq_iso_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] strap_addr,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic              iso_bit,
    output logic              mdio_irq_en,
    output logic [4:0]        stn_addr
);
    logic wr_ctrl, wr_cfg, wr_adr;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_cfg  = reg_wr && (reg_addr == RA_IRQCFG);
    assign wr_adr  = reg_wr && (reg_addr == RA_STNADR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iso_bit     <= (strap_addr == '0);
            mdio_irq_en <= 1'b0;
            stn_addr    <= strap_addr;
        end else begin
            if (wr_ctrl) iso_bit     <= reg_wdata[ISO_BIT];
            if (wr_cfg)  mdio_irq_en <= reg_wdata[MDIO_BIT];
            if (wr_adr)  stn_addr    <= reg_wdata[ADR_LSB +: 5];
        end
    end
endmodule

// File: rtl/pii_iso_fsm.sv
module pii_iso_fsm
    import phy_irq_iso_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] strap_addr,
    input  logic       iso_bit,
    input  logic [4:0] stn_addr,
    output logic       isolate,
    output logic       mii_out_en,
    output logic       tx_accept
);
    iso_state_t state_q, state_d;
    logic       want_iso;

    assign want_iso = iso_bit || (stn_addr == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ISO_LIVE: if (want_iso)  state_d = ISO_HELD;
            ISO_HELD: if (!want_iso) state_d = ISO_LIVE;
            default:  state_d = ISO_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= (strap_addr == '0) ? ISO_HELD : ISO_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ISO_LIVE: begin
                isolate    = 1'b0;
                mii_out_en = 1'b1;
                tx_accept  = 1'b1;
            end
            default: begin
                isolate    = 1'b1;
                mii_out_en = 1'b0;
                tx_accept  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/phy_irq_iso_ctrl.sv
module phy_irq_iso_ctrl
    import phy_irq_iso_pkg::*;
#(
    parameter int N_EVT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        strap_addr,
    input  logic [N_EVT-1:0]  evt_pulse,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq,
    output logic              irq_on_mdio,
    output logic              isolate,
    output logic              mii_out_en,
    output logic              tx_accept
);
    localparam int FLAG_PAD = REG_DW - N_EVT;

    logic [N_EVT-1:0] flags, mask;
    logic             iso_bit;
    logic [4:0]       stn_addr;
    logic             clr_rd;
    logic             mask_we;

    assign clr_rd  = reg_rd && (reg_addr == RA_FLAGS);
    assign mask_we = reg_wr && (reg_addr == RA_MASK);

    pii_irq_bank #(.N_EVT(N_EVT)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_pulse),
        .clr        (clr_rd),
        .mask_we    (mask_we),
        .mask_wdata (reg_wdata[N_EVT-1:0]),
        .flags      (flags),
        .mask       (mask),
        .irq        (irq)
    );

    pii_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_addr  (strap_addr),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .iso_bit     (iso_bit),
        .mdio_irq_en (irq_on_mdio),
        .stn_addr    (stn_addr)
    );

    pii_iso_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_addr (strap_addr),
        .iso_bit    (iso_bit),
        .stn_addr   (stn_addr),
        .isolate    (isolate),
        .mii_out_en (mii_out_en),
        .tx_accept  (tx_accept)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                RA_CTRL:   reg_rdata[ISO_BIT]      = iso_bit;
                RA_IRQCFG: reg_rdata[MDIO_BIT]     = irq_on_mdio;
                RA_STNADR: reg_rdata[ADR_LSB +: 5] = stn_addr;
                RA_MASK:   reg_rdata = {{FLAG_PAD{1'b0}}, mask};
                RA_FLAGS:  reg_rdata = {{FLAG_PAD{1'b0}}, flags};
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pii_checker.sv
module pii_checker #(
    parameter int N_EVT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_EVT-1:0] evt_pulse,
    input logic [N_EVT-1:0] mask,
    input logic [N_EVT-1:0] flags,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic [4:0]       reg_addr,
    input logic             irq,
    input logic             isolate,
    input logic             mii_out_en,
    input logic             tx_accept,
    input logic [4:0]       stn_addr
);
    AST_ENABLED_EVENT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_pulse & mask)) && !(reg_wr && reg_addr == 5'h1D)) |=> irq); // R1

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse[0]) |=> flags[0]); // R2

    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 5'h1E && evt_pulse == '0) |=> !irq); // R3

    AST_ZERO_ADDR_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
        (stn_addr == 5'd0) |=> isolate); // R8

    AST_ISOLATE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        isolate |-> (!mii_out_en && !tx_accept)); // R9
endmodule

bind phy_irq_iso_ctrl pii_checker #(.N_EVT(N_EVT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_pulse  (evt_pulse),
    .mask       (mask),
    .flags      (flags),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .irq        (irq),
    .isolate    (isolate),
    .mii_out_en (mii_out_en),
    .tx_accept  (tx_accept),
    .stn_addr   (stn_addr)
);

// File: tb/phy_irq_iso_ctrl_test.sv
module phy_irq_iso_ctrl_test;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    strap_addr = 5'd3;
    logic [NE-1:0] evt_pulse = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          irq, irq_on_mdio, isolate, mii_out_en, tx_accept;

    int total = 0;
    int bad = 0;

    logic [NE-1:0] m_flags, m_mask;
    logic          m_iso_bit, m_cfg, m_iso;
    logic [4:0]    m_adr;

    phy_irq_iso_ctrl #(.N_EVT(NE)) uut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .evt_pulse(evt_pulse),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .irq_on_mdio(irq_on_mdio),
        .isolate(isolate), .mii_out_en(mii_out_en), .tx_accept(tx_accept)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata(input logic rd, input logic [4:0] a);
        logic [15:0] v = '0;
        if (rd) begin
            case (a)
                5'h00: v[10] = m_iso_bit;
                5'h17: v[11] = m_cfg;
                5'h19: v[15:11] = m_adr;
                5'h1D: v[NE-1:0] = m_mask;
                5'h1E: v[NE-1:0] = m_flags;
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    task automatic check_outs();
        chk(irq == |(m_flags & m_mask), "R1 irq", {15'd0, irq}, {15'd0, |(m_flags & m_mask)});
        chk(irq_on_mdio == m_cfg, "R6 irq_on_mdio", {15'd0, irq_on_mdio}, {15'd0, m_cfg});
        chk(isolate == m_iso, "R8 isolate", {15'd0, isolate}, {15'd0, m_iso});
        chk(mii_out_en == !m_iso && tx_accept == !m_iso, "R9 enables",
            {14'd0, mii_out_en, tx_accept}, {14'd0, !m_iso, !m_iso});
    endtask

    task automatic step(input logic [NE-1:0] ev, input logic rd, input logic wr,
                        input logic [4:0] a, input logic [15:0] wd);
        logic iso_next;
        @(negedge clk);
        check_outs();
        evt_pulse = ev; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        chk(reg_rdata == exp_rdata(rd, a), "R10 read data", reg_rdata, exp_rdata(rd, a));
        @(posedge clk);
        iso_next = m_iso_bit || (m_adr == 5'd0);
        m_flags = ((rd && a == 5'h1E) ? '0 : m_flags) | ev;
        if (wr && a == 5'h00) m_iso_bit = wd[10];
        if (wr && a == 5'h17) m_cfg = wd[11];
        if (wr && a == 5'h19) m_adr = wd[15:11];
        if (wr && a == 5'h1D) m_mask = wd[NE-1:0];
        m_iso = iso_next;
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_addr = s;
        evt_pulse = '0; reg_rd = 0; reg_wr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_flags = '0; m_mask = '0; m_cfg = 0; m_adr = s;
        m_iso_bit = (s == 5'd0); m_iso = (s == 5'd0);
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [4:0] alist [5];
        void'($urandom(32'd1234));
        alist = '{5'h00, 5'h17, 5'h19, 5'h1D, 5'h1E};

        // R7: reset with nonzero strap
        do_reset(5'd3);
        #1;
        chk(isolate == 1'b0, "R7 no isolate strap=3", {15'd0, isolate}, 16'd0);
        step('0, 1, 0, 5'h00, 0);
        step('0, 1, 0, 5'h19, 0);
        step('0, 1, 0, 5'h1D, 0);

        // R1 R2: masked event sets flag, no irq until enabled
        step(4'b0100, 0, 0, 0, 0);
        step('0, 0, 0, 0, 0);
        chk(irq == 1'b0, "R1 masked no irq", {15'd0, irq}, 16'd0);
        step('0, 0, 1, 5'h1D, 16'h0004);
        step('0, 0, 0, 0, 0);
        #1 chk(irq == 1'b1, "R1 unmasked irq", {15'd0, irq}, 16'd1);
        // R3 read clears
        step('0, 1, 0, 5'h1E, 0);
        step('0, 0, 0, 0, 0);
        // R4 event with clearing read
        step(4'b0001, 0, 0, 0, 0);
        step(4'b0100, 1, 0, 5'h1E, 0);
        step('0, 1, 0, 5'h1E, 0);
        chk(m_flags == '0, "R4 model cleared", {12'd0, m_flags}, 16'd0);
        // R5 write to flags ignored
        step(4'b0010, 0, 0, 0, 0);
        step('0, 0, 1, 5'h1E, 16'h0000);
        step('0, 1, 0, 5'h1E, 0);
        // R6
        step('0, 0, 1, 5'h17, 16'h0800);
        step('0, 1, 0, 5'h17, 0);
        // R8 zero address isolates, bit 10 unchanged; R9 access works
        step('0, 0, 1, 5'h19, 16'h0000);
        step('0, 0, 0, 0, 0);
        step('0, 1, 0, 5'h00, 0);
        step('0, 0, 1, 5'h19, 16'h2800);
        step('0, 0, 1, 5'h00, 16'h0400);
        step('0, 0, 0, 0, 0);
        step('0, 0, 1, 5'h00, 16'h0000);
        step('0, 0, 0, 0, 0);

        // R7: reset with zero strap
        do_reset(5'd0);
        #1;
        chk(isolate == 1'b1, "R7 isolate strap=0", {15'd0, isolate}, 16'd1);
        step('0, 1, 0, 5'h00, 0);
        step('0, 0, 1, 5'h19, 16'h0800);
        step('0, 0, 1, 5'h00, 16'h0000);
        step('0, 0, 0, 0, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [NE-1:0] ev;
            int op;
            logic [4:0] a;
            logic [15:0] wd;
            ev = ($urandom % 4 == 0) ? NE'($urandom) : '0;
            op = $urandom % 4;
            a = ($urandom % 8 == 0) ? 5'($urandom) : alist[$urandom % 5];
            wd = 16'($urandom);
            if (a == 5'h19 && ($urandom % 3 == 0)) wd[15:11] = 5'd0;
            step(ev, op == 1 || op == 2, op == 3, a, wd);
        end
        @(negedge clk);
        check_outs();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule